// File: doc/BRIEF.md
# Programmable n-Word Delay Controller

This block sequences a line-buffer memory so that the word leaving the buffer is the word that entered it exactly n clock cycles earlier. Write and read share one clock. A start pulse captures the requested delay, the delay method and the speed grade. From then on the block drives four strobes to the buffer: a write-pointer clear, a read-pointer clear, a write enable and a read enable. It also raises a flag that marks the first cycle in which delayed data appears. A later start pulse restarts the sequence at any time, so the same pin serves for a resync.

Three methods are available. In recirculate mode both pointers are cleared together every n cycles, so storage is reused over an n-word window. In stagger mode the write pointer is cleared once, the read pointer is cleared n cycles later, and both pointers then run freely. In hold-off mode both pointers are cleared together and the read enable is withheld for n cycles, which leaves the read pointer n words behind. The buffer only tolerates delays between a floor set by its speed grade and its full depth. Any request outside that range is pulled to the nearest limit, and an error flag reports the correction.

The controller is a five-state machine. IDLE is the state after reset. On start it moves to RECIRC, STAGGER or HOLD according to the mode. STAGGER moves to FREE once the read clear has been issued at cycle n. HOLD moves to FREE in the cycle before the read enable is released. A start pulse in any state re-enters the entry state of the newly sampled mode with the phase counter at zero.

Top module: `nword_delay_ctrl`

## Requirements
- R1: At start, a delay below the floor is replaced by the floor: 21 when `fast_grade` is 1 and 15 when it is 0. `clamp_err` is 1 from the cycle after that start.
- R2: At start, a delay above 5048 is replaced by 5048 and `clamp_err` is set. `clamp_err` keeps its value until the next start, which clears it if that start's request is legal.
- R3: With `mode` 0 (or 3, which behaves the same), counting the first cycle after the start edge as cycle 0, `wptr_clr` and `rptr_clr` are both 1 in every cycle k where k mod n = 0, and 0 in all other cycles.
- R4: With `mode` 1, `wptr_clr` is 1 only in cycle 0 and `rptr_clr` is 1 only in cycle n. Neither strobe pulses again.
- R5: With `mode` 2, both clears are 1 only in cycle 0, and `rd_go` is 0 in cycles 0 to n-1 and 1 from cycle n on.
- R6: After a start, `wr_go` stays 1 until reset. `rd_go` is 1 in every cycle except the hold-off window of R5.
- R7: `out_valid` is 0 in cycles 0 to n-1 and 1 from cycle n until the next start.
- R8: While reset is asserted, and after reset until the first start, all six outputs are 0.
- R9: `delay_n`, `mode` and `fast_grade` are sampled only in the start cycle. Changes to them during a run do not alter the outputs.
- R10: A start during a run restarts the sequence at cycle 0 using the newly sampled settings.
- R11: In mode 0 with n = 5048, both pointers are cleared every 5048 cycles, which gives a one-line delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write/read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start or resync pulse |
| delay_n | input | NW (13) | Requested delay in words |
| mode | input | 2 | 0/3 recirculate, 1 stagger, 2 hold-off |
| fast_grade | input | 1 | 1 selects the faster grade (floor 21), 0 floor 15 |
| wptr_clr | output | 1 | Clear the buffer write pointer this cycle |
| rptr_clr | output | 1 | Clear the buffer read pointer this cycle |
| wr_go | output | 1 | Buffer write enable |
| rd_go | output | 1 | Buffer read enable (buffer output floats when 0) |
| out_valid | output | 1 | Read data now carries delayed input |
| clamp_err | output | 1 | The last start requested an out-of-range delay |

## Verification
If the phase counter loses a count, the damage shows up at the next scheduled strobe. In recirculate mode the pointer clears drift off multiples of n within one period. In stagger mode the single read clear lands on the wrong cycle, and in hold-off mode `rd_go` is released early or late. A state register stuck in the wrong state shows up within one cycle of a start, because the cycle-0 clears or the read enable will not match the mode. A bad clamp is caught at the latest n cycles after start, when `out_valid` should rise. Each run is compared cycle by cycle over at least two delay periods, so a fault cannot hide behind a single correct pulse.

// File: rtl/nwd_pkg.sv
`timescale 1ns/1ps
package nwd_pkg;

    localparam int NWD_MAX_N    = 5048;
    localparam int NWD_MIN_FAST = 21;
    localparam int NWD_MIN_SLOW = 15;

    typedef enum logic [1:0] {
        MODE_RECIRC  = 2'd0,
        MODE_STAGGER = 2'd1,
        MODE_HOLDOFF = 2'd2,
        MODE_RECIRC2 = 2'd3
    } dly_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RECIRC  = 3'd1,
        ST_STAGGER = 3'd2,
        ST_HOLD    = 3'd3,
        ST_FREE    = 3'd4
    } dly_state_e;

    function automatic dly_state_e entry_state(input logic [1:0] m);
        dly_state_e s;
        unique case (m)
            MODE_STAGGER: s = ST_STAGGER;
            MODE_HOLDOFF: s = ST_HOLD;
            default:      s = ST_RECIRC;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nwd_clamp.sv
`timescale 1ns/1ps
module nwd_clamp #(
    parameter int MAX_N    = 5048,
    parameter int MIN_FAST = 21,
    parameter int MIN_SLOW = 15,
    parameter int NW       = 13
) (
    input  logic [NW-1:0] raw_n,
    input  logic          fast,
    output logic [NW-1:0] n_eff,
    output logic          bad
);
    localparam logic [NW-1:0] CEIL  = NW'(MAX_N);
    localparam logic [NW-1:0] FLR_F = NW'(MIN_FAST);
    localparam logic [NW-1:0] FLR_S = NW'(MIN_SLOW);

    logic [NW-1:0] floor_v;
    logic          too_low;
    logic          too_high;

    always_comb begin
        floor_v  = fast ? FLR_F : FLR_S;
        too_low  = raw_n < floor_v;
        too_high = raw_n > CEIL;
        bad      = too_low | too_high;
        if (too_low)
            n_eff = floor_v;
        else if (too_high)
            n_eff = CEIL;
        else
            n_eff = raw_n;
    end

    // R1
    always_comb begin
        if (!$isunknown({raw_n, fast}))
            clamp_range_chk: assert (n_eff >= FLR_S && n_eff <= CEIL && (n_eff == raw_n || bad));
    end

endmodule

// File: rtl/nwd_phase_ctr.sv
`timescale 1ns/1ps
module nwd_phase_ctr #(
    parameter int NW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [NW-1:0] lim,
    output logic [NW-1:0] cnt,
    output logic          at_lim
);
    assign at_lim = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run) begin
            if (at_lim)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    // R3
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && at_lim) |=> (cnt == '0));

    // R7
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !at_lim) |=> (cnt == $past(cnt) + 1'b1));

    // R10
    ctr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

endmodule

// File: rtl/nword_delay_ctrl.sv
`timescale 1ns/1ps
module nword_delay_ctrl
    import nwd_pkg::*;
#(
    parameter int MAX_N    = NWD_MAX_N,
    parameter int MIN_FAST = NWD_MIN_FAST,
    parameter int MIN_SLOW = NWD_MIN_SLOW,
    parameter int NW       = $clog2(MAX_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] delay_n,
    input  logic [1:0]    mode,
    input  logic          fast_grade,
    output logic          wptr_clr,
    output logic          rptr_clr,
    output logic          wr_go,
    output logic          rd_go,
    output logic          out_valid,
    output logic          clamp_err
);

    dly_state_e    st_q, st_d;
    logic [NW-1:0] n_q;
    logic [NW-1:0] n_eff;
    logic          n_bad;
    logic          lap_q;
    logic          err_q;
    logic [NW-1:0] cnt;
    logic [NW-1:0] lim;
    logic          at_lim;
    logic          ctr_run;

    nwd_clamp #(
        .MAX_N    (MAX_N),
        .MIN_FAST (MIN_FAST),
        .MIN_SLOW (MIN_SLOW),
        .NW       (NW)
    ) u_clamp (
        .raw_n (delay_n),
        .fast  (fast_grade),
        .n_eff (n_eff),
        .bad   (n_bad)
    );

    // STAGGER counts 0..n so the read clear lands on cycle n; others 0..n-1
    assign lim     = (st_q == ST_STAGGER) ? n_q : (n_q - 1'b1);
    assign ctr_run = (st_q == ST_RECIRC) || (st_q == ST_STAGGER) || (st_q == ST_HOLD);

    nwd_phase_ctr #(
        .NW (NW)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .run    (ctr_run),
        .lim    (lim),
        .cnt    (cnt),
        .at_lim (at_lim)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    st_d = ST_IDLE;
            ST_RECIRC:  st_d = ST_RECIRC;
            ST_STAGGER: if (at_lim) st_d = ST_FREE;
            ST_HOLD:    if (at_lim) st_d = ST_FREE;
            ST_FREE:    st_d = ST_FREE;
            default:    st_d = ST_IDLE;
        endcase
        if (start)
            st_d = entry_state(mode);
    end

    // state register and sampled settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            n_q   <= NW'(MIN_SLOW);
            lap_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start) begin
                n_q   <= n_eff;
                err_q <= n_bad;
                lap_q <= 1'b0;
            end else if (st_q == ST_RECIRC && at_lim) begin
                lap_q <= 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        wptr_clr  = 1'b0;
        rptr_clr  = 1'b0;
        wr_go     = 1'b0;
        rd_go     = 1'b0;
        out_valid = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RECIRC: begin
                wr_go     = 1'b1;
                rd_go     = 1'b1;
                wptr_clr  = (cnt == '0);
                rptr_clr  = (cnt == '0);
                out_valid = lap_q;
            end
            ST_STAGGER: begin
                wr_go     = 1'b1;
                rd_go     = 1'b1;
                wptr_clr  = (cnt == '0);
                rptr_clr  = at_lim;
                out_valid = at_lim;
            end
            ST_HOLD: begin
                wr_go    = 1'b1;
                wptr_clr = (cnt == '0);
                rptr_clr = (cnt == '0);
            end
            ST_FREE: begin
                wr_go     = 1'b1;
                rd_go     = 1'b1;
                out_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign clamp_err = err_q;

    // R3
    joint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode != MODE_STAGGER) |=> (wptr_clr && rptr_clr));

    // R4
    lone_rclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_clr && !wptr_clr) |-> out_valid);

    // R5
    rd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_go) |-> $past(start));

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> wr_go);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !out_valid);

endmodule

// File: tb/nword_delay_ctrl_tb.sv
`timescale 1ns/1ps
module nword_delay_ctrl_tb;

    localparam int NW = 13;

    typedef struct packed {
        logic [1:0]    mode;
        logic [NW-1:0] n;
        logic          fast;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 13'd21,   1'b1},
        '{2'd1, 13'd30,   1'b1},
        '{2'd2, 13'd16,   1'b0},
        '{2'd0, 13'd5,    1'b0},
        '{2'd2, 13'd3,    1'b1},
        '{2'd1, 13'd15,   1'b0},
        '{2'd3, 13'd17,   1'b0},
        '{2'd1, 13'd8000, 1'b1},
        '{2'd2, 13'd40,   1'b1},
        '{2'd0, 13'd5048, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] delay_n = '0;
    logic [1:0]    mode = 2'd0;
    logic          fast_grade = 1'b0;
    logic          wptr_clr, rptr_clr, wr_go, rd_go, out_valid, clamp_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    nword_delay_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .delay_n    (delay_n),
        .mode       (mode),
        .fast_grade (fast_grade),
        .wptr_clr   (wptr_clr),
        .rptr_clr   (rptr_clr),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .out_valid  (out_valid),
        .clamp_err  (clamp_err)
    );

    task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp, input int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, k, act, exp);
        end
    endtask

    function automatic int eff_n(input vec_t v);
        int lo;
        lo = v.fast ? 21 : 15;
        if (int'(v.n) < lo) return lo;
        if (int'(v.n) > 5048) return 5048;
        return int'(v.n);
    endfunction

    task automatic run_vec(input vec_t v, input bit big);
        int  e;
        bit  err_e;
        logic [1:0] cl_e;
        logic [1:0] go_e;
        e     = eff_n(v);
        err_e = (int'(v.n) != e);
        // R10: start may arrive while a previous run is active
        @(negedge clk);
        delay_n    = v.n;
        mode       = v.mode;
        fast_grade = v.fast;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2 * e + 4; k++) begin
            if (k == 2) begin
                // R9: disturb the settings mid-run
                delay_n    = ~v.n;
                mode       = ~v.mode;
                fast_grade = ~v.fast;
            end
            unique case (v.mode)
                2'd1:    cl_e = {k == 0, k == e};
                2'd2:    cl_e = {k == 0, k == 0};
                default: cl_e = {(k % e) == 0, (k % e) == 0};
            endcase
            go_e = {1'b1, (v.mode == 2'd2) ? (k >= e) : 1'b1};
            if (big)
                check("R11 clears", {4'd0, wptr_clr, rptr_clr}, {4'd0, cl_e}, k);
            else if (v.mode == 2'd1)
                check("R4 clears", {4'd0, wptr_clr, rptr_clr}, {4'd0, cl_e}, k);
            else if (v.mode == 2'd2)
                check("R5 clears", {4'd0, wptr_clr, rptr_clr}, {4'd0, cl_e}, k);
            else
                check("R3 clears", {4'd0, wptr_clr, rptr_clr}, {4'd0, cl_e}, k);
            check("R6 enables", {4'd0, wr_go, rd_go}, {4'd0, go_e}, k);
            check("R7 valid", {5'd0, out_valid}, {5'd0, k >= e}, k);
            if (int'(v.n) > 5048)
                check("R2 error", {5'd0, clamp_err}, {5'd0, err_e}, k);
            else
                check("R1 error", {5'd0, clamp_err}, {5'd0, err_e}, k);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset
        check("R8 in reset", {wptr_clr, rptr_clr, wr_go, rd_go, out_valid, clamp_err}, 6'd0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 idle", {wptr_clr, rptr_clr, wr_go, rd_go, out_valid, clamp_err}, 6'd0, 0);

        for (int i = 0; i < NV; i++)
            run_vec(VECS[i], i == NV - 1);

        // R8: asynchronous reset in the middle of a run
        @(negedge clk);
        delay_n = 13'd25; mode = 2'd2; fast_grade = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R8 async", {wptr_clr, rptr_clr, wr_go, rd_go, out_valid, clamp_err}, 6'd0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 after", {wptr_clr, rptr_clr, wr_go, rd_go, out_valid, clamp_err}, 6'd0, 0);

        // R2: an illegal request followed by a legal one clears the flag
        run_vec('{2'd1, 13'd6000, 1'b0}, 1'b0);
        run_vec('{2'd0, 13'd15, 1'b0}, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule